// File: doc/BRIEF.md
# External Interrupt Control and Capture Register

This block is one 16-bit control and status register inside an interrupt controller. It conditions two external interrupt request pins. Both pins are active-low and asynchronous. The block then drives one request line for each pin toward the arbitration logic. Each time the core enters an interrupt service routine, the block records the priority level and vector number of that entry. Software reads both back through the same register.

Pin A is always low-level sensitive. Pin B is low-level sensitive by default. Software can switch it to falling-edge sensitivity, in which case a detected edge latches a pending flag. The flag holds until the next service-routine entry acknowledges it, or until software writes the mode bit back to 0. While the device is in a stop or wait state, pin B behaves as level-sensitive whatever the mode bit holds. A global disable bit blocks both request outputs.

Top module: `ext_irq_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x001C and both request outputs and `irq_disable` are low. Bit 4 reads 1, bits 3 and 2 read 1 for idle pins, and every other bit reads 0.
- R2: Bit 3 returns the synchronized level of pin B and bit 2 returns that of pin A. A pin change appears there two clock edges after it is applied.
- R3: `req_a` is high exactly when the synchronized pin A level is 0 and bit 5 is 0.
- R4: With bit 1 at 0, `req_b` is high exactly when the synchronized pin B level is 0 and bit 5 is 0.
- R5: With bit 1 at 1 and `low_power_mode` low, a falling edge on pin B sets a pending flag. `req_b` rises three edges after the pin falls. It stays high after the pin returns high, and it drops on the edge that samples `isr_enter` high.
- R6: A register write with bit 1 at 0 clears the pending flag. Setting bit 1 to 1 again afterwards does not raise `req_b`.
- R7: While `low_power_mode` is high, `req_b` follows the synchronized pin B level as in R4, whatever bit 1 holds. Edges seen in this state set no pending flag.
- R8: Bit 5 is a read/write global disable that resets to 0. While it is 1, `req_a` and `req_b` are both low, and `irq_disable` mirrors it.
- R9: On an edge where `isr_enter` is high, bits 14:13 take `isr_level` and bits 12:6 take `isr_vector`. A later entry overwrites both fields.
- R10: Without an entry, bits 14:13 and 12:6 hold their values. Register writes do not change them.
- R11: Bit 4 always reads 1 and bits 15 and 0 always read 0. Writes to bits 15:6, 4:2 and 0 have no effect. Only bits 5 and 1 are writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| pin_a_n | input | 1 | Raw external request A, active low |
| pin_b_n | input | 1 | Raw external request B, active low |
| low_power_mode | input | 1 | Stop/wait state indicator; forces B to level sensing |
| isr_enter | input | 1 | Strobe on the cycle the core enters a service routine |
| isr_level | input | 2 | Priority level presented at entry |
| isr_vector | input | 7 | Vector address bits [7:1] at entry |
| irq_disable | output | 1 | Global disable state |
| req_a | output | 1 | Conditioned request for pin A |
| req_b | output | 1 | Conditioned request for pin B |

## Verification
Several properties are checked on every cycle. The reserved and constant bits, the blocking effect of the disable bit, and the level behaviour of both requests (including B while in the low-power state) are all checked this way. So are the capture-or-hold rule for the level and vector fields and the write path of the mode bit. What only the bench scenarios show is the history-dependent behaviour of edge mode. That covers a pending flag surviving the pin's return high, its release by entry or by a mode write, and the exact two- and three-edge latencies from a pin change. The bench also sweeps every level and vector value through the capture path.

// File: rtl/ext_irq_pkg.sv
// Package: shared widths and bit positions of the interrupt control register.
// Assumes a 16-bit register; positions are fixed because software decodes them.
package ext_irq_pkg;
    localparam int REG_W   = 16;
    localparam int LVL_W   = 2;
    localparam int VEC_W   = 7;
    localparam int LVL_LSB = 13;
    localparam int LVL_MSB = LVL_LSB + LVL_W - 1;
    localparam int VEC_LSB = 6;
    localparam int VEC_MSB = VEC_LSB + VEC_W - 1;
    localparam int DIS_BIT = 5;
    localparam int RSV_BIT = 4;
    localparam int PB_BIT  = 3;
    localparam int PA_BIT  = 2;
    localparam int MODE_BIT = 1;
    localparam int NUM_PINS = 2;
    localparam int IDX_A    = 0;
    localparam int IDX_B    = 1;
endpackage

// File: rtl/irq_pin_sync.sv
// Module: multi-stage synchronizer for asynchronous active-low pins.
// Assumes pins idle high, so every stage resets to 1 (no request).
module irq_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_raw,
    output logic [WIDTH-1:0] pin_sync
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        // Shift the raw pin level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], pin_raw[g]};
        end
        assign pin_sync[g] = chain[LAST];
    end
endmodule

// File: rtl/irq_edge_pend.sv
// Module: falling-edge detector with a pending flag for one synchronized pin.
// Assumes lvl_n is already synchronized. A write clear wins over a new edge,
// a new edge wins over an acknowledge so that no edge is lost.
module irq_edge_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_n,
    input  logic edge_en,
    input  logic ack,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic fall;

    // Remember the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl_n;
    end

    assign fall = prev_q & ~lvl_n & edge_en;

    // Hold the pending flag until cleared by write or acknowledged by entry.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (clr)  pend <= 1'b0;
        else if (fall) pend <= 1'b1;
        else if (ack)  pend <= 1'b0;
    end
endmodule

// File: rtl/isr_ctx_capture.sv
// Module: captures priority level and vector on service-routine entry.
// Assumes the entry strobe is a single-cycle pulse; nested entries overwrite.
module isr_ctx_capture #(
    parameter int LVL_W = 2,
    parameter int VEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter,
    input  logic [LVL_W-1:0] lvl_in,
    input  logic [VEC_W-1:0] vec_in,
    output logic [LVL_W-1:0] lvl_q,
    output logic [VEC_W-1:0] vec_q
);
    // Load the context fields only on an entry strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            vec_q <= '0;
        end else if (enter) begin
            lvl_q <= lvl_in;
            vec_q <= vec_in;
        end
    end
endmodule

// File: rtl/ext_irq_ctrl_reg.sv
// Module: external interrupt control and capture register (top).
// Conditions two active-low pins into requests, records entry context and
// presents every field on a combinational read port. Assumes a single clock.
module ext_irq_ctrl_reg
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             pin_a_n,
    input  logic             pin_b_n,
    input  logic             low_power_mode,
    input  logic             isr_enter,
    input  logic [LVL_W-1:0] isr_level,
    input  logic [VEC_W-1:0] isr_vector,
    output logic             irq_disable,
    output logic             req_a,
    output logic             req_b
);
    logic [NUM_PINS-1:0] pin_sync;
    logic                dis_q;
    logic                mode_q;
    logic                edge_live;
    logic                pend_b;
    logic                mode_clr;
    logic [LVL_W-1:0]    lvl_q;
    logic [VEC_W-1:0]    vec_q;

    irq_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  ({pin_b_n, pin_a_n}),
        .pin_sync (pin_sync)
    );

    // Writable control bits: global disable and pin B mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q  <= 1'b0;
            mode_q <= 1'b0;
        end else if (reg_wr_en) begin
            dis_q  <= reg_wdata[DIS_BIT];
            mode_q <= reg_wdata[MODE_BIT];
        end
    end

    assign edge_live = mode_q & ~low_power_mode;
    assign mode_clr  = reg_wr_en & ~reg_wdata[MODE_BIT];

    irq_edge_pend u_edge_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_n   (pin_sync[IDX_B]),
        .edge_en (edge_live),
        .ack     (isr_enter),
        .clr     (mode_clr),
        .pend    (pend_b)
    );

    isr_ctx_capture #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_ctx (
        .clk    (clk),
        .rst_n  (rst_n),
        .enter  (isr_enter),
        .lvl_in (isr_level),
        .vec_in (isr_vector),
        .lvl_q  (lvl_q),
        .vec_q  (vec_q)
    );

    // Gate the conditioned requests with the global disable.
    always_comb begin
        req_a = ~dis_q & ~pin_sync[IDX_A];
        req_b = ~dis_q & (edge_live ? pend_b : ~pin_sync[IDX_B]);
    end

    assign irq_disable = dis_q;

    // Assemble the read view of every field.
    always_comb begin
        reg_rdata                   = '0;
        reg_rdata[LVL_MSB:LVL_LSB]  = lvl_q;
        reg_rdata[VEC_MSB:VEC_LSB]  = vec_q;
        reg_rdata[DIS_BIT]          = dis_q;
        reg_rdata[RSV_BIT]          = 1'b1;
        reg_rdata[PB_BIT]           = pin_sync[IDX_B];
        reg_rdata[PA_BIT]           = pin_sync[IDX_A];
        reg_rdata[MODE_BIT]         = mode_q;
    end
endmodule

// File: rtl/ext_irq_ctrl_reg_chk.sv
// Module: property checker for the interrupt control register, bound to the top.
// Assumes it sees only the top's ports.
module ext_irq_ctrl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        low_power_mode,
    input logic        isr_enter,
    input logic [1:0]  isr_level,
    input logic [6:0]  isr_vector,
    input logic        irq_disable,
    input logic        req_a,
    input logic        req_b
);
    // R11
    rsv_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[4] && !reg_rdata[15] && !reg_rdata[0]);

    // R8
    dis_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[5] |-> (irq_disable && !req_a && !req_b));

    // R3
    req_a_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_a == (!reg_rdata[2] && !irq_disable));

    // R7
    lp_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_power_mode |-> (req_b == (!reg_rdata[3] && !irq_disable)));

    // R9
    ctx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_enter |=> (reg_rdata[14:13] == $past(isr_level) &&
                       reg_rdata[12:6] == $past(isr_vector)));

    // R10
    ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !isr_enter |=> ($stable(reg_rdata[14:13]) && $stable(reg_rdata[12:6])));

    // R6
    mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_rdata[1] == $past(reg_wdata[1])));
endmodule

bind ext_irq_ctrl_reg ext_irq_ctrl_reg_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr_en      (reg_wr_en),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .low_power_mode (low_power_mode),
    .isr_enter      (isr_enter),
    .isr_level      (isr_level),
    .isr_vector     (isr_vector),
    .irq_disable    (irq_disable),
    .req_a          (req_a),
    .req_b          (req_b)
);

// File: tb/ext_irq_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps pin, mode and context combinations with arithmetic expectations.
module ext_irq_ctrl_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        pin_a_n = 1'b1;
    logic        pin_b_n = 1'b1;
    logic        low_power_mode = 1'b0;
    logic        isr_enter = 1'b0;
    logic [1:0]  isr_level = '0;
    logic [6:0]  isr_vector = '0;
    logic        irq_disable;
    logic        req_a;
    logic        req_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ext_irq_ctrl_reg dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pin_a_n(pin_a_n), .pin_b_n(pin_b_n),
        .low_power_mode(low_power_mode), .isr_enter(isr_enter),
        .isr_level(isr_level), .isr_vector(isr_vector),
        .irq_disable(irq_disable), .req_a(req_a), .req_b(req_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        reg_wr_en = 1'b1; reg_wdata = d;
        step(1);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic enter(input logic [1:0] l, input logic [6:0] v);
        isr_enter = 1'b1; isr_level = l; isr_vector = v;
        step(1);
        isr_enter = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(3);
        // R1 reset state
        chk("R1 rdata", reg_rdata, 32'h001C);
        chk("R1 outs", {irq_disable, req_a, req_b}, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 rdata after release", reg_rdata, 32'h001C);

        // R2 latency: one edge is not enough, two are
        pin_a_n = 1'b0;
        step(1);
        chk("R2 one edge", reg_rdata[2], 1);
        step(1);
        chk("R2 two edges", reg_rdata[2], 0);
        pin_a_n = 1'b1;
        step(2);

        // R3 R4 R7 R8 sweep over level-sensing cases
        for (int lp = 0; lp < 2; lp++)
            for (int md = 0; md < 2; md++) begin
                if (md == 1 && lp == 0) continue;
                low_power_mode = lp[0];
                for (int ds = 0; ds < 2; ds++)
                    for (int p = 0; p < 4; p++) begin
                        wr({10'b0, ds[0], 3'b0, md[0], 1'b0});
                        pin_a_n = p[0]; pin_b_n = p[1];
                        step(2);
                        chk("R2 pins", reg_rdata[3:2], p[1:0]);
                        chk("R3 req_a", req_a, (ds == 0) && !p[0]);
                        chk(lp ? "R7 req_b" : "R4 req_b", req_b, (ds == 0) && !p[1]);
                        chk("R8 mirror", irq_disable, ds[0]);
                    end
            end
        low_power_mode = 1'b0;
        pin_a_n = 1'b1; pin_b_n = 1'b1;
        wr(16'h0000);
        step(2);

        // R7 edges while in low power set no pending flag
        low_power_mode = 1'b1;
        wr(16'h0002);
        pin_b_n = 1'b0; step(3); pin_b_n = 1'b1; step(3);
        low_power_mode = 1'b0;
        step(1);
        chk("R7 no pending", req_b, 0);

        // R5 edge mode: latency, hold and acknowledge
        pin_b_n = 1'b0;
        step(2);
        chk("R5 before latch", req_b, 0);
        step(1);
        chk("R5 latched", req_b, 1);
        pin_b_n = 1'b1;
        step(3);
        chk("R5 held high", req_b, 1);
        wr(16'h0022);
        chk("R8 blocks pending", req_b, 0);
        wr(16'h0002);
        chk("R8 pending kept", req_b, 1);
        enter(2'd1, 7'h10);
        chk("R5 acked", req_b, 0);

        // R6 mode write 0 clears pending
        pin_b_n = 1'b0; step(3); pin_b_n = 1'b1; step(3);
        chk("R6 pending set", req_b, 1);
        wr(16'h0000);
        wr(16'h0002);
        chk("R6 cleared", req_b, 0);
        wr(16'h0000);

        // R9 R10 sweep all levels and vectors
        for (int l = 0; l < 4; l++)
            for (int v = 0; v < 128; v++) begin
                enter(l[1:0], v[6:0]);
                chk("R9 capture", reg_rdata[14:6], {l[1:0], v[6:0]});
            end
        isr_level = 2'd0; isr_vector = 7'd0;
        step(2);
        chk("R10 hold", reg_rdata[14:6], {2'd3, 7'h7F});
        enter(2'd2, 7'h2A);
        enter(2'd1, 7'h55);
        chk("R9 nested overwrite", reg_rdata[14:6], {2'd1, 7'h55});

        // R10 R11 write all ones: only bits 5 and 1 change
        wr(16'hFFFF);
        chk("R11 write ones", reg_rdata, {1'b0, 2'd1, 7'h55, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0});
        wr(16'h0000);
        chk("R10 R11 write zeros", reg_rdata, {1'b0, 2'd1, 7'h55, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule